// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block turns four asynchronous external interrupt request pins into clean, registered request lines for a downstream interrupt controller. Every pin is first brought into the core clock domain. Each line then has its own choice of trigger type (level or edge) and its own polarity (high level or rising edge, or low level or falling edge). Qualifying activity sets a sticky pending flag for that line. Each flag drives the matching request output directly.

Software uses a small register port to program the trigger-type and polarity bits. It reads the pending flags through the same port and clears them by writing ones to the flag register. The downstream controller decides whether a line is serviced as a fast or a normal interrupt. That decision, pin multiplexing and wake-up handling are outside this block.

Register selection uses `reg_addr`: 0 is the pending-flag register (read, write-one-to-clear), 1 is the trigger-type register (bit set = edge, clear = level), 2 is the polarity register (bit set = high/rising, clear = low/falling), and 3 reads as zero and ignores writes. Bit n of every register belongs to line n.

Top module: `extint_conditioner`

## Requirements
- R1: After reset, the trigger-type, polarity and pending-flag registers all read zero and all request outputs are low.
- R2: Each pin passes through a two-stage synchroniser. A pin change driven between clock edges reaches the pending flag on the third rising edge after the change, and not earlier.
- R3: With trigger type edge (bit 1) and polarity bit 1, a rising edge on the pin sets the flag and a falling edge does not.
- R4: With trigger type edge and polarity bit 0, a falling edge on the pin sets the flag and a rising edge does not.
- R5: In edge mode, a set flag stays set after the pin returns to its idle level, until software clears it.
- R6: Writing to address 0 clears each flag whose write-data bit is 1, on the edge of the write. Bits written as 0 leave their flags unchanged.
- R7: In level mode (bit 0), the flag is set while the pin is at its active level: low for polarity 0, high for polarity 1. A clear write has no effect while the level is still active. A clear write does take effect once the level has gone away, and until then the flag stays set.
- R8: When an edge event and a clear write for the same line land on the same clock edge, the flag ends up set.
- R9: The four lines are independent. Activity or a clear on one line never changes another line's flag.
- R10: Each request output equals its line's pending flag, as read at address 0.
- R11: Addresses 1 and 2 read back the trigger-type and polarity values last written. Address 3 reads zero. Reprogramming these registers while the pins are idle sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 4 | Raw asynchronous interrupt pins, bit n is line n |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register select: 0 flags, 1 trigger type, 2 polarity, 3 reserved |
| reg_wdata | input | 4 | Register write data, bit n is line n |
| reg_rdata | output | 4 | Combinational read data for the selected register |
| irq_req | output | 4 | Request lines to the interrupt controller |

## Verification
A pin change is due on `irq_req` three rising edges after it is driven. A register write, or a clear, is visible one edge after the write strobe. A change of polarity acts on the flag one edge after that, because the new polarity bit has to be registered first. Read data is combinational and is due in the same cycle as the address. The driver records each expectation with the exact cycle it is due, computed from these latencies. The monitor compares `irq_req` or `reg_rdata` only in that cycle, half a period after the edge. Some expectations are pinned one cycle early to show that nothing arrives ahead of time. Any expectation that is left unchecked counts as a failure.

// File: rtl/extint_pkg.sv
// Package: shared register selectors and sizing for the external
// interrupt input conditioner.
// Assumes: register address is two bits wide.
package extint_pkg;

    localparam int unsigned REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_FLAGS = 2'd0,
        SEL_TRIG  = 2'd1,
        SEL_POL   = 2'd2,
        SEL_RSVD  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/extint_sync.sv
// Module: extint_sync
// Brings NUM_LINES asynchronous pins into the clock domain through a chain
// of STAGES flops per line.
// Assumes: the pins are slow compared with clk. RST_VAL gives the idle
// level that the chain shows during and right after reset.
module extint_sync #(
    parameter int unsigned NUM_LINES = 4,
    parameter int unsigned STAGES    = 2,
    parameter logic [NUM_LINES-1:0] RST_VAL = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] raw_i,
    output logic [NUM_LINES-1:0] sync_o
);

    logic [NUM_LINES-1:0] chain_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: capture the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= RST_VAL;
                    else        chain_q[g] <= raw_i;
                end
            end else begin : g_next
                // Later stages: shift the previous stage along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= RST_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/extint_trigger.sv
// Module: extint_trigger
// Per line, decides from the synchronised pin, the trigger-type bit and the
// polarity bit whether the pending flag must be set this cycle.
// Assumes: sync_i is already in the clock domain. The previous-sample flop
// resets to RST_VAL, matching the synchroniser, so reset causes no false edge.
module extint_trigger #(
    parameter int unsigned NUM_LINES = 4,
    parameter logic [NUM_LINES-1:0] RST_VAL = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] sync_i,
    input  logic [NUM_LINES-1:0] trig_edge_i,
    input  logic [NUM_LINES-1:0] pol_high_i,
    output logic [NUM_LINES-1:0] set_o
);

    logic [NUM_LINES-1:0] prev_q;

    // Keep last cycle's synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= sync_i;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_line
            logic rise, fall, edge_hit, level_hit;
            // Classify this line's activity against its programming.
            always_comb begin
                rise      = sync_i[g] & ~prev_q[g];
                fall      = ~sync_i[g] & prev_q[g];
                edge_hit  = pol_high_i[g] ? rise : fall;
                level_hit = pol_high_i[g] ? sync_i[g] : ~sync_i[g];
                set_o[g]  = trig_edge_i[g] ? edge_hit : level_hit;
            end
        end
    endgenerate

endmodule

// File: rtl/extint_regs.sv
// Module: extint_regs
// Holds the trigger-type and polarity registers, turns flag writes into a
// per-line clear vector and multiplexes read data.
// Assumes: one write per reg_wr_en cycle. Reads have no side effects.
module extint_regs
    import extint_pkg::*;
#(
    parameter int unsigned NUM_LINES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [NUM_LINES-1:0]  wdata_i,
    input  logic [NUM_LINES-1:0]  flags_i,
    output logic [NUM_LINES-1:0]  trig_edge_o,
    output logic [NUM_LINES-1:0]  pol_high_o,
    output logic [NUM_LINES-1:0]  clr_o,
    output logic [NUM_LINES-1:0]  rdata_o
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr_i);

    // Update the trigger-type register on writes to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)                          trig_edge_o <= '0;
        else if (wr_en_i && sel == SEL_TRIG) trig_edge_o <= wdata_i;
    end

    // Update the polarity register on writes to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)                         pol_high_o <= '0;
        else if (wr_en_i && sel == SEL_POL) pol_high_o <= wdata_i;
    end

    // Write-one-to-clear request toward the flag cells.
    always_comb begin
        clr_o = (wr_en_i && sel == SEL_FLAGS) ? wdata_i : '0;
    end

    // Read-data selection.
    always_comb begin
        unique case (sel)
            SEL_FLAGS: rdata_o = flags_i;
            SEL_TRIG:  rdata_o = trig_edge_o;
            SEL_POL:   rdata_o = pol_high_o;
            default:   rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/extint_flags.sv
// Module: extint_flags
// Sticky pending flags, one per line. A set request beats a clear request
// in the same cycle.
// Assumes: set_i is asserted for every cycle a level is active, and for
// one cycle per qualifying edge.
module extint_flags #(
    parameter int unsigned NUM_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] set_i,
    input  logic [NUM_LINES-1:0] clr_i,
    output logic [NUM_LINES-1:0] flag_o
);

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_cell
            // Set has priority; otherwise hold unless cleared.
            always_ff @(posedge clk) begin
                if (!rst_n)        flag_o[g] <= 1'b0;
                else if (set_i[g]) flag_o[g] <= 1'b1;
                else if (clr_i[g]) flag_o[g] <= 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/extint_conditioner.sv
// Module: extint_conditioner (top)
// Conditions external interrupt pins into sticky request lines: synchroniser,
// trigger decision, pending flags and register port.
// Assumes: pins idle high while reset is applied, matching SYNC_RST_VAL.
module extint_conditioner
    import extint_pkg::*;
#(
    parameter int unsigned NUM_LINES    = 4,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter logic [NUM_LINES-1:0] SYNC_RST_VAL = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  pin_i,
    input  logic                  reg_wr_en,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [NUM_LINES-1:0]  reg_wdata,
    output logic [NUM_LINES-1:0]  reg_rdata,
    output logic [NUM_LINES-1:0]  irq_req
);

    logic [NUM_LINES-1:0] pin_sync;
    logic [NUM_LINES-1:0] trig_edge;
    logic [NUM_LINES-1:0] pol_high;
    logic [NUM_LINES-1:0] set_req;
    logic [NUM_LINES-1:0] clr_vec;
    logic [NUM_LINES-1:0] flag_q;

    extint_sync #(
        .NUM_LINES (NUM_LINES),
        .STAGES    (SYNC_STAGES),
        .RST_VAL   (SYNC_RST_VAL)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_i),
        .sync_o (pin_sync)
    );

    extint_trigger #(
        .NUM_LINES (NUM_LINES),
        .RST_VAL   (SYNC_RST_VAL)
    ) trig_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (pin_sync),
        .trig_edge_i (trig_edge),
        .pol_high_i  (pol_high),
        .set_o       (set_req)
    );

    extint_regs #(
        .NUM_LINES (NUM_LINES)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (reg_wr_en),
        .addr_i      (reg_addr),
        .wdata_i     (reg_wdata),
        .flags_i     (flag_q),
        .trig_edge_o (trig_edge),
        .pol_high_o  (pol_high),
        .clr_o       (clr_vec),
        .rdata_o     (reg_rdata)
    );

    extint_flags #(
        .NUM_LINES (NUM_LINES)
    ) flags_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_req),
        .clr_i  (clr_vec),
        .flag_o (flag_q)
    );

    // Request lines are the pending flags.
    assign irq_req = flag_q;

endmodule

// File: rtl/extint_conditioner_chk.sv
// Module: extint_conditioner_chk
// Assertion checker bound into extint_conditioner. Relates the set and clear
// requests, the trigger-type bits and the flags over time.
// Assumes: bound with the top's internal signal names.
module extint_conditioner_chk #(
    parameter int unsigned NUM_LINES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] set_req,
    input logic [NUM_LINES-1:0] clr_vec,
    input logic [NUM_LINES-1:0] trig_edge,
    input logic [NUM_LINES-1:0] pol_high,
    input logic [NUM_LINES-1:0] flag_q,
    input logic [NUM_LINES-1:0] irq_req
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (flag_q == '0 && trig_edge == '0 && pol_high == '0)); // R1

    AST_REQ_IS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == flag_q); // R10

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_line
            AST_FLAG_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag_q[g]) |-> $past(set_req[g])); // R2

            AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (trig_edge[g] && flag_q[g] && !clr_vec[g]) |=> flag_q[g]); // R5

            AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_q[g] && clr_vec[g] && !set_req[g]) |=> !flag_q[g]); // R6

            AST_LEVEL_BLOCKS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (!trig_edge[g] && set_req[g] && clr_vec[g]) |=> flag_q[g]); // R7

            AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (trig_edge[g] && set_req[g] && clr_vec[g]) |=> flag_q[g]); // R8
        end
    endgenerate

endmodule

bind extint_conditioner extint_conditioner_chk #(
    .NUM_LINES (NUM_LINES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_req   (set_req),
    .clr_vec   (clr_vec),
    .trig_edge (trig_edge),
    .pol_high  (pol_high),
    .flag_q    (flag_q),
    .irq_req   (irq_req)
);

// File: tb/extint_conditioner_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues each expectation with its due cycle;
// the monitor compares in that cycle, half a period after the edge.
module extint_conditioner_tb_top;

    localparam logic [1:0] A_FLAGS = 2'd0;
    localparam logic [1:0] A_TRIG  = 2'd1;
    localparam logic [1:0] A_POL   = 2'd2;
    localparam logic [1:0] A_RSVD  = 2'd3;

    typedef struct {
        int         due;
        bit         is_rd;
        logic [3:0] val;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pins = 4'hF;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [3:0] reg_wdata = 4'h0;
    logic [3:0] reg_rdata;
    logic [3:0] irq_req;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fails = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    extint_conditioner dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pins),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_req   (irq_req)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic exp_irq(input int d, input logic [3:0] v, input string t);
        sb.push_back('{cyc + d, 1'b0, v, t});
    endtask

    task automatic exp_rd(input logic [1:0] a, input logic [3:0] v, input string t);
        reg_addr = a;
        sb.push_back('{cyc, 1'b1, v, t});
        tick(1);
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        tick(1);
        reg_wr_en = 1'b0;
        reg_wdata = 4'h0;
    endtask

    // Monitor: pop and compare every expectation due in this cycle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].due <= cyc) begin
                    logic [3:0] act;
                    act = sb[i].is_rd ? reg_rdata : irq_req;
                    n_checks++;
                    if (sb[i].due < cyc || act !== sb[i].val) begin
                        n_fails++;
                        $display("FAIL %s: actual %b expected %b (cycle %0d)",
                                 sb[i].tag, act, sb[i].val, cyc);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    // Driver: stimulus with expectations timed from the stated latencies.
    initial begin
        tick(4);
        rst_n = 1'b1;
        exp_irq(0, 4'b0000, "R1 requests low");
        exp_rd(A_FLAGS, 4'b0000, "R1 flags");
        exp_rd(A_TRIG,  4'b0000, "R1 trigger type");
        exp_rd(A_POL,   4'b0000, "R1 polarity");

        // Level, active low on line 0
        pins[0] = 1'b0;
        exp_irq(2, 4'b0000, "R2 not early");
        exp_irq(3, 4'b0001, "R2 R7 level low sets");
        tick(4);
        exp_irq(1, 4'b0001, "R7 clear ignored while active");
        wr(A_FLAGS, 4'b0001);
        pins[0] = 1'b1;
        exp_irq(3, 4'b0001, "R7 stays set after release");
        tick(4);
        exp_irq(1, 4'b0000, "R6 clear after release");
        wr(A_FLAGS, 4'b0001);

        // Level, active high on line 1 (pin already high)
        exp_irq(1, 4'b0000, "R7 polarity needs a cycle");
        exp_irq(2, 4'b0010, "R7 level high sets");
        wr(A_POL, 4'b0010);
        tick(2);
        pins[1] = 1'b0;
        tick(3);
        exp_irq(1, 4'b0000, "R7 clear once inactive");
        wr(A_FLAGS, 4'b0010);
        tick(1);

        // Edge mode: line 2 rising, line 3 falling
        wr(A_TRIG, 4'b1100);
        wr(A_POL, 4'b0110);
        exp_rd(A_TRIG, 4'b1100, "R11 trigger readback");
        exp_rd(A_POL,  4'b0110, "R11 polarity readback");
        exp_rd(A_RSVD, 4'b0000, "R11 reserved reads zero");
        exp_irq(0, 4'b0000, "R11 no flag from reprogramming");

        pins[2] = 1'b0;
        exp_irq(3, 4'b0000, "R3 falling ignored");
        tick(4);
        pins[2] = 1'b1;
        exp_irq(2, 4'b0000, "R2 edge not early");
        exp_irq(3, 4'b0100, "R3 rising sets");
        tick(4);
        pins[2] = 1'b0;
        exp_irq(3, 4'b0100, "R5 sticky after idle");
        tick(4);

        pins[3] = 1'b0;
        exp_irq(3, 4'b1100, "R4 falling sets");
        tick(4);
        exp_irq(1, 4'b0100, "R6 R9 clear one line only");
        wr(A_FLAGS, 4'b1000);
        pins[3] = 1'b1;
        exp_irq(3, 4'b0100, "R4 rising ignored");
        tick(4);
        exp_irq(1, 4'b0100, "R6 zero write no effect");
        wr(A_FLAGS, 4'b0000);
        exp_irq(1, 4'b0000, "R6 clear line 2");
        wr(A_FLAGS, 4'b0100);

        // Edge and clear on the same clock edge
        pins[2] = 1'b1;
        exp_irq(3, 4'b0100, "R8 set wins over clear");
        tick(2);
        wr(A_FLAGS, 4'b0100);
        tick(2);

        // Independent simultaneous activity, readback matches requests
        pins[3] = 1'b0;
        pins[2] = 1'b0;
        exp_irq(3, 4'b1100, "R9 lines independent");
        tick(3);
        exp_rd(A_FLAGS, 4'b1100, "R10 request equals flag readback");
        tick(3);

        if (sb.size() != 0) begin
            n_checks++;
            n_fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule